// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block performs unsigned and signed multiplication and division at byte and word widths, using the accumulator-pair convention. The low half of AX (or all of AX) is the implied operand. Results are split across AH:AL or DX:AX, and the remainder of a division always lands in the high half. A one-cycle start strobe captures the operation select, the width select, the AX and DX inputs and the source operand. After a fixed number of cycles a one-cycle done pulse presents the new AX and DX values.

The work is done one bit per cycle. Multiplication uses a shift-add engine and division uses a restoring engine, both operating on magnitudes. A small stage before the engines takes the magnitudes of signed operands, and a stage after them restores the signs.

A division by zero, or a division whose quotient does not fit the destination, raises a divide-error request for the surrounding processor's type-0 interrupt. In that case AX and DX come back unchanged. The block only raises the request; it does not dispatch the interrupt.

Top module: `muldiv_seq`

## Requirements
- R1: With wide=0 and op=0 (unsigned) or op=1 (signed), ax_out equals ax_in[7:0] times src_in[7:0] as a 16-bit product, and dx_out equals dx_in.
- R2: With wide=1 and op=0 or op=1, the 32-bit product of ax_in and src_in is returned with its high word on dx_out and its low word on ax_out.
- R3: With wide=0 and op=2, ax_in is divided by src_in[7:0]. The quotient goes to ax_out[7:0], the remainder to ax_out[15:8], and dx_out equals dx_in.
- R4: With wide=1 and op=2, the dividend {dx_in, ax_in} is divided by src_in. The quotient goes to ax_out and the remainder to dx_out.
- R5: op=3 divides two's complement operands with the same result layout as op=2. The quotient truncates toward zero, and the remainder carries the sign of the dividend.
- R6: A zero divisor in op=2 or op=3 sets div_err with done, and ax_out and dx_out equal the captured ax_in and dx_in.
- R7: div_err is also set, with the same result rule as R6, when an unsigned quotient exceeds the destination width or a signed quotient is outside the destination's signed range. Examples are -128/-1 at byte width and -32768/-1 at word width.
- R8: An accepted start raises busy on the next cycle. done rises for exactly one cycle 9 cycles (byte) or 17 cycles (word) after the accepting clock edge, and busy falls in that same cycle.
- R9: A start while busy is high is ignored, and the running operation completes with its own operands. A start in the done cycle is accepted.
- R10: div_err is high only together with done, and never after a multiply.
- R11: After reset, busy, done and div_err are low and ax_out and dx_out are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 0 unsigned mul, 1 signed mul, 2 unsigned div, 3 signed div |
| wide | input | 1 | 0 byte width, 1 word width |
| ax_in | input | WORD_W | Accumulator input |
| dx_in | input | WORD_W | High accumulator input |
| src_in | input | WORD_W | Source operand (low half used at byte width) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| ax_out | output | WORD_W | Updated accumulator |
| dx_out | output | WORD_W | Updated high accumulator |
| div_err | output | 1 | Divide-error request, valid with done |

## Verification
The hardest cases to reach are the signed divide boundaries. Here the dividend's high half is smaller than the divisor magnitude, so the quotient magnitude fits the width, yet the signed result lies just outside the legal range; -256/2 is legal while -128/-1 is not. The stimulus sets up these boundaries and the unsigned ones directly, alongside a long run of mixed pseudo-random operations. A further sequence pulses start during a running operation, and another issues a new start in the done cycle itself, to exercise the acceptance rule.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      OP_MUL  = 2'd0,
      OP_IMUL = 2'd1,
      OP_DIV  = 2'd2,
      OP_IDIV = 2'd3
   } md_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } md_state_e;
endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
   import muldiv_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [1:0]          op,
   input  logic                wide,
   input  logic [WORD_W-1:0]   ax,
   input  logic [WORD_W-1:0]   dx,
   input  logic [WORD_W-1:0]   src,
   output logic                is_div,
   output logic                sgn,
   output logic [2*WORD_W-1:0] mag_a,
   output logic [WORD_W-1:0]   mag_b,
   output logic                neg_res,
   output logic                neg_rem,
   output logic                div_zero
);
   localparam int HALF = WORD_W / 2;
   localparam int DW   = 2 * WORD_W;

   md_op_e            op_e;
   logic [DW-1:0]     a_ext;
   logic [WORD_W-1:0] b_ext;
   logic              a_neg;
   logic              b_neg;

   assign op_e = md_op_e'(op);

   always_comb begin
      is_div = (op_e == OP_DIV) || (op_e == OP_IDIV);
      sgn    = (op_e == OP_IMUL) || (op_e == OP_IDIV);
      if (wide) begin
         b_ext = src;
      end else if (sgn) begin
         b_ext = {{(WORD_W-HALF){src[HALF-1]}}, src[HALF-1:0]};
      end else begin
         b_ext = {{(WORD_W-HALF){1'b0}}, src[HALF-1:0]};
      end
      if (is_div && wide) begin
         a_ext = {dx, ax};
      end else if (is_div || wide) begin
         a_ext = sgn ? {{(DW-WORD_W){ax[WORD_W-1]}}, ax}
                     : {{(DW-WORD_W){1'b0}}, ax};
      end else begin
         a_ext = sgn ? {{(DW-HALF){ax[HALF-1]}}, ax[HALF-1:0]}
                     : {{(DW-HALF){1'b0}}, ax[HALF-1:0]};
      end
      a_neg    = sgn & a_ext[DW-1];
      b_neg    = sgn & b_ext[WORD_W-1];
      mag_a    = a_neg ? -a_ext : a_ext;
      mag_b    = b_neg ? -b_ext : b_ext;
      neg_res  = a_neg ^ b_neg;
      neg_rem  = a_neg;
      div_zero = (b_ext == '0);
   end
endmodule

// File: rtl/muldiv_mul_engine.sv
module muldiv_mul_engine #(
   parameter int WORD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [WORD_W-1:0]   mcand_in,
   input  logic [WORD_W-1:0]   mplier_in,
   output logic [2*WORD_W-1:0] prod
);
   localparam int DW = 2 * WORD_W;

   logic [DW-1:0]     mcand;
   logic [WORD_W-1:0] mplier;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand  <= '0;
         mplier <= '0;
         prod   <= '0;
      end else if (load) begin
         mcand  <= {{WORD_W{1'b0}}, mcand_in};
         mplier <= mplier_in;
         prod   <= '0;
      end else if (step) begin
         if (mplier[0]) prod <= prod + mcand;
         mcand  <= mcand << 1;
         mplier <= mplier >> 1;
      end
   end
endmodule

// File: rtl/muldiv_div_engine.sv
module muldiv_div_engine #(
   parameter int WORD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic                wide,
   input  logic [2*WORD_W-1:0] dividend,
   input  logic [WORD_W-1:0]   divisor,
   output logic [WORD_W-1:0]   quo,
   output logic [WORD_W-1:0]   rem,
   output logic                mag_ovf
);
   localparam int HALF = WORD_W / 2;
   localparam int DW   = 2 * WORD_W;

   logic [WORD_W-1:0] dvs;
   logic [WORD_W-1:0] lo_sh;
   logic [WORD_W-1:0] hi_init;
   logic [WORD_W-1:0] lo_init;
   logic [WORD_W:0]   trial;
   logic              fits;

   always_comb begin
      hi_init = wide ? dividend[DW-1:WORD_W]
                     : {{(WORD_W-HALF){1'b0}}, dividend[WORD_W-1:HALF]};
      lo_init = wide ? dividend[WORD_W-1:0]
                     : {dividend[HALF-1:0], {(WORD_W-HALF){1'b0}}};
      trial   = {rem, lo_sh[WORD_W-1]};
      fits    = trial >= {1'b0, dvs};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvs     <= '0;
         lo_sh   <= '0;
         quo     <= '0;
         rem     <= '0;
         mag_ovf <= 1'b0;
      end else if (load) begin
         dvs     <= divisor;
         lo_sh   <= lo_init;
         quo     <= '0;
         rem     <= hi_init;
         mag_ovf <= hi_init >= divisor;
      end else if (step) begin
         rem   <= fits ? (trial[WORD_W-1:0] - dvs) : trial[WORD_W-1:0];
         quo   <= {quo[WORD_W-2:0], fits};
         lo_sh <= lo_sh << 1;
      end
   end
endmodule

// File: rtl/muldiv_post.sv
module muldiv_post #(
   parameter int WORD_W = 16
) (
   input  logic                is_div,
   input  logic                sgn,
   input  logic                wide,
   input  logic                neg_res,
   input  logic                neg_rem,
   input  logic                div_zero,
   input  logic                mag_ovf,
   input  logic [2*WORD_W-1:0] prod,
   input  logic [WORD_W-1:0]   quo,
   input  logic [WORD_W-1:0]   rem,
   input  logic [WORD_W-1:0]   ax_in,
   input  logic [WORD_W-1:0]   dx_in,
   output logic [WORD_W-1:0]   ax_res,
   output logic [WORD_W-1:0]   dx_res,
   output logic                err
);
   localparam int HALF = WORD_W / 2;
   localparam int DW   = 2 * WORD_W;

   logic [DW-1:0]     p_s;
   logic [WORD_W-1:0] q_s;
   logic [WORD_W-1:0] r_s;
   logic [WORD_W-1:0] lim_pos;
   logic [WORD_W-1:0] lim_neg;
   logic              rng_bad;

   always_comb begin
      p_s     = neg_res ? -prod : prod;
      q_s     = neg_res ? -quo : quo;
      r_s     = neg_rem ? -rem : rem;
      lim_pos = wide ? {1'b0, {(WORD_W-1){1'b1}}}
                     : {{(WORD_W-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
      lim_neg = wide ? {1'b1, {(WORD_W-1){1'b0}}}
                     : {{(WORD_W-HALF){1'b0}}, 1'b1, {(HALF-1){1'b0}}};
      rng_bad = sgn & (neg_res ? (quo > lim_neg) : (quo > lim_pos));
      err     = is_div & (div_zero | mag_ovf | rng_bad);
      if (err) begin
         ax_res = ax_in;
         dx_res = dx_in;
      end else if (!is_div) begin
         ax_res = p_s[WORD_W-1:0];
         dx_res = wide ? p_s[DW-1:WORD_W] : dx_in;
      end else if (wide) begin
         ax_res = q_s;
         dx_res = r_s;
      end else begin
         ax_res = {r_s[HALF-1:0], q_s[HALF-1:0]};
         dx_res = dx_in;
      end
   end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
   import muldiv_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic              wide,
   input  logic [WORD_W-1:0] ax_in,
   input  logic [WORD_W-1:0] dx_in,
   input  logic [WORD_W-1:0] src_in,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] ax_out,
   output logic [WORD_W-1:0] dx_out,
   output logic              div_err
);
   localparam int HALF  = WORD_W / 2;
   localparam int DW    = 2 * WORD_W;
   localparam int CNT_W = $clog2(WORD_W + 1);

   generate
      if ((WORD_W < 4) || ((WORD_W % 2) != 0)) begin : g_bad_width
         $error("muldiv_seq: WORD_W must be even and at least 4");
      end
   endgenerate

   md_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic              accept;
   logic              step;

   logic              p_is_div, p_sgn, p_neg_res, p_neg_rem, p_zero;
   logic [DW-1:0]     p_mag_a;
   logic [WORD_W-1:0] p_mag_b;

   logic              is_div_q, sgn_q, wide_q, neg_res_q, neg_rem_q, zero_q;
   logic [WORD_W-1:0] ax_q, dx_q;

   logic [DW-1:0]     prod;
   logic [WORD_W-1:0] quo, rem;
   logic              mag_ovf;
   logic [WORD_W-1:0] ax_res, dx_res;
   logic              err;

   assign busy   = (state != ST_IDLE);
   assign accept = start && (state == ST_IDLE);
   assign step   = (state == ST_RUN);

   muldiv_prep #(.WORD_W(WORD_W)) u_prep (
      .op(op), .wide(wide), .ax(ax_in), .dx(dx_in), .src(src_in),
      .is_div(p_is_div), .sgn(p_sgn), .mag_a(p_mag_a), .mag_b(p_mag_b),
      .neg_res(p_neg_res), .neg_rem(p_neg_rem), .div_zero(p_zero)
   );

   muldiv_mul_engine #(.WORD_W(WORD_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
      .mcand_in(p_mag_a[WORD_W-1:0]), .mplier_in(p_mag_b), .prod(prod)
   );

   muldiv_div_engine #(.WORD_W(WORD_W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(step), .wide(wide),
      .dividend(p_mag_a), .divisor(p_mag_b),
      .quo(quo), .rem(rem), .mag_ovf(mag_ovf)
   );

   muldiv_post #(.WORD_W(WORD_W)) u_post (
      .is_div(is_div_q), .sgn(sgn_q), .wide(wide_q),
      .neg_res(neg_res_q), .neg_rem(neg_rem_q), .div_zero(zero_q),
      .mag_ovf(mag_ovf), .prod(prod), .quo(quo), .rem(rem),
      .ax_in(ax_q), .dx_in(dx_q),
      .ax_res(ax_res), .dx_res(dx_res), .err(err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         is_div_q  <= 1'b0;
         sgn_q     <= 1'b0;
         wide_q    <= 1'b0;
         neg_res_q <= 1'b0;
         neg_rem_q <= 1'b0;
         zero_q    <= 1'b0;
         ax_q      <= '0;
         dx_q      <= '0;
         done      <= 1'b0;
         div_err   <= 1'b0;
         ax_out    <= '0;
         dx_out    <= '0;
      end else begin
         done    <= 1'b0;
         div_err <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  is_div_q  <= p_is_div;
                  sgn_q     <= p_sgn;
                  wide_q    <= wide;
                  neg_res_q <= p_neg_res;
                  neg_rem_q <= p_neg_rem;
                  zero_q    <= p_zero;
                  ax_q      <= ax_in;
                  dx_q      <= dx_in;
                  cnt       <= wide ? CNT_W'(WORD_W) : CNT_W'(HALF);
                  state     <= ST_RUN;
               end
            end
            ST_RUN: begin
               cnt <= cnt - CNT_W'(1);
               if (cnt == CNT_W'(1)) state <= ST_FIN;
            end
            ST_FIN: begin
               done    <= 1'b1;
               div_err <= err;
               ax_out  <= ax_res;
               dx_out  <= dx_res;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              op_hi,
   input logic              wide,
   input logic [WORD_W-1:0] ax_in,
   input logic [WORD_W-1:0] dx_in,
   input logic              busy,
   input logic              done,
   input logic              div_err,
   input logic [WORD_W-1:0] ax_out,
   input logic [WORD_W-1:0] dx_out
);
   localparam int LW = $clog2(WORD_W + 2) + 1;

   logic              cap_div, cap_wide;
   logic [WORD_W-1:0] cap_ax, cap_dx;
   logic [LW-1:0]     lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_div  <= 1'b0;
         cap_wide <= 1'b0;
         cap_ax   <= '0;
         cap_dx   <= '0;
         lat      <= '0;
      end else if (start && !busy) begin
         cap_div  <= op_hi;
         cap_wide <= wide;
         cap_ax   <= ax_in;
         cap_dx   <= dx_in;
         lat      <= '0;
      end else if (busy) begin
         lat <= lat + LW'(1);
      end
   end

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   a_r8_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat == (cap_wide ? LW'(WORD_W + 1) : LW'(WORD_W / 2 + 1))));
   a_r10_err_only_done: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |-> done);
   a_r10_mul_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_div) |-> !div_err);
   a_r6_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_err) |-> ((ax_out == cap_ax) && (dx_out == cap_dx)));
   a_r1_byte_keeps_dx: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_wide) |-> (dx_out == cap_dx));
endmodule

bind muldiv_seq muldiv_seq_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op_hi(op[1]), .wide(wide),
   .ax_in(ax_in), .dx_in(dx_in), .busy(busy), .done(done),
   .div_err(div_err), .ax_out(ax_out), .dx_out(dx_out)
);

// File: tb/muldiv_seq_test.sv
`timescale 1ns/1ps
module muldiv_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        wide = 1'b0;
   logic [15:0] ax_in = '0, dx_in = '0, src_in = '0;
   logic        busy, done, div_err;
   logic [15:0] ax_out, dx_out;

   int checks = 0;
   int errors = 0;
   string force_tag = "";

   always #2 clk = ~clk;

   muldiv_seq #(.WORD_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
      .ax_in(ax_in), .dx_in(dx_in), .src_in(src_in),
      .busy(busy), .done(done), .ax_out(ax_out), .dx_out(dx_out),
      .div_err(div_err)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void calc(input logic [1:0] o, input logic w,
                                input logic [15:0] a, input logic [15:0] d,
                                input logic [15:0] s,
                                output logic [15:0] eax, output logic [15:0] edx,
                                output logic eerr, output string tag);
      longint p, dvd, dvs, q, r;
      eerr = 1'b0; eax = a; edx = d;
      tag = w ? "R2" : "R1";
      if (o == 2'd0 || o == 2'd1) begin
         if (!w) begin
            p = (o == 2'd0) ? longint'(a[7:0]) * longint'(s[7:0])
                            : longint'($signed(a[7:0])) * longint'($signed(s[7:0]));
            eax = p[15:0];
         end else begin
            p = (o == 2'd0) ? longint'(a) * longint'(s)
                            : longint'($signed(a)) * longint'($signed(s));
            eax = p[15:0]; edx = p[31:16];
         end
      end else begin
         tag = (o == 2'd3) ? "R5" : (w ? "R4" : "R3");
         if (o == 2'd2) begin
            dvd = w ? longint'({d, a}) : longint'(a);
            dvs = w ? longint'(s) : longint'(s[7:0]);
         end else begin
            dvd = w ? longint'($signed({d, a})) : longint'($signed(a));
            dvs = w ? longint'($signed(s)) : longint'($signed(s[7:0]));
         end
         if (dvs == 0) begin
            eerr = 1'b1; tag = "R6";
         end else begin
            q = dvd / dvs; r = dvd % dvs;
            if (o == 2'd2) eerr = w ? (q > 65535) : (q > 255);
            else eerr = w ? (q > 32767 || q < -32768) : (q > 127 || q < -128);
            if (eerr) tag = "R7";
            else if (w) begin eax = q[15:0]; edx = r[15:0]; end
            else eax = {r[7:0], q[7:0]};
         end
      end
   endfunction

   // cycle-level reference model
   logic        m_busy, m_done, m_err;
   logic [15:0] m_ax, m_dx;
   int          m_left;
   string       m_tag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
         m_ax <= '0; m_dx <= '0; m_err <= 1'b0; m_tag <= "";
      end else begin : mdl
         logic [15:0] tax, tdx;
         logic terr;
         string ttag;
         m_done <= 1'b0;
         if (!m_busy && start) begin
            calc(op, wide, ax_in, dx_in, src_in, tax, tdx, terr, ttag);
            m_busy <= 1'b1;
            m_left <= wide ? 17 : 9;
            m_ax <= tax; m_dx <= tdx; m_err <= terr;
            m_tag <= (force_tag != "") ? force_tag : ttag;
         end else if (m_busy) begin
            m_left <= m_left - 1;
            if (m_left == 1) begin
               m_busy <= 1'b0;
               m_done <= 1'b1;
            end
         end
      end
   end

   bit run_cmp = 1'b0;
   always @(negedge clk) begin
      if (run_cmp) begin
         chk("R8", "busy", 32'(busy), 32'(m_busy));
         chk("R8", "done", 32'(done), 32'(m_done));
         if (done && m_done) begin
            chk(m_tag, "ax_out", 32'(ax_out), 32'(m_ax));
            chk(m_tag, "dx_out", 32'(dx_out), 32'(m_dx));
            chk(m_tag, "div_err", 32'(div_err), 32'(m_err));
         end else begin
            chk("R10", "div_err idle", 32'(div_err), 32'(0));
         end
      end
   end

   // caller is at a negedge; returns at the negedge where done is seen
   task automatic issue(input logic [1:0] o, input logic w, input logic [15:0] a,
                        input logic [15:0] d, input logic [15:0] s);
      op = o; wide = w; ax_in = a; dx_in = d; src_in = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "busy", 32'(busy), 32'(0));
      chk("R11", "done", 32'(done), 32'(0));
      chk("R11", "div_err", 32'(div_err), 32'(0));
      chk("R11", "ax_out", 32'(ax_out), 32'(0));
      chk("R11", "dx_out", 32'(dx_out), 32'(0));
      run_cmp = 1'b1;

      // R1 byte products
      issue(2'd0, 1'b0, 16'h12FF, 16'hBEEF, 16'h00FF);
      issue(2'd1, 1'b0, 16'h00FF, 16'h1234, 16'h00FF);
      issue(2'd1, 1'b0, 16'h0080, 16'h0000, 16'h0080);
      issue(2'd1, 1'b0, 16'h0080, 16'h0000, 16'h007F);
      // R2 word products
      issue(2'd0, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF);
      issue(2'd1, 1'b1, 16'h8000, 16'h0000, 16'h8000);
      issue(2'd1, 1'b1, 16'hFFFF, 16'h0000, 16'h0002);
      // R3 byte divides
      issue(2'd2, 1'b0, 16'h0064, 16'hAAAA, 16'h0007);
      issue(2'd2, 1'b0, 16'h00FF, 16'h5555, 16'h0001);
      // R4 word divides
      issue(2'd2, 1'b1, 16'h0000, 16'h0001, 16'h0002);
      issue(2'd2, 1'b1, 16'hFFFF, 16'hFFFE, 16'hFFFF);
      // R5 signed divides
      issue(2'd3, 1'b0, 16'hFFF9, 16'h0000, 16'h0002);
      issue(2'd3, 1'b0, 16'h0007, 16'h0000, 16'h00FE);
      issue(2'd3, 1'b0, 16'hFF00, 16'h0000, 16'h0002);
      issue(2'd3, 1'b1, 16'h8000, 16'hFFFF, 16'h0001);
      // R6 zero divisor
      issue(2'd2, 1'b0, 16'h1234, 16'h5678, 16'hFF00);
      issue(2'd3, 1'b1, 16'h1234, 16'h5678, 16'h0000);
      // R7 quotient overflow
      issue(2'd2, 1'b0, 16'hFFFF, 16'h0000, 16'h00FF);
      issue(2'd3, 1'b0, 16'hFF80, 16'h0000, 16'h00FF);
      issue(2'd3, 1'b1, 16'h8000, 16'hFFFF, 16'hFFFF);
      issue(2'd2, 1'b1, 16'h0000, 16'h0005, 16'h0005);

      // R9 start while busy is ignored
      force_tag = "R9";
      op = 2'd2; wide = 1'b0; ax_in = 16'h03E8; dx_in = 16'h0; src_in = 16'h0021;
      start = 1'b1;
      @(negedge clk);
      force_tag = "";
      op = 2'd0; ax_in = 16'h0011; src_in = 16'h0022;
      repeat (3) @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      // R9 back-to-back start in the done cycle
      force_tag = "R9";
      issue(2'd1, 1'b1, 16'h7FFF, 16'h0, 16'h8001);
      force_tag = "";
      issue(2'd3, 1'b1, 16'h0000, 16'hFFFF, 16'h0100);

      // mixed pseudo-random operations
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r1, r2;
         r1 = $urandom;
         r2 = $urandom;
         issue(r1[1:0], r1[2], r2[15:0], r2[31:16],
               r1[3] ? {8'h00, r1[15:8]} : r1[31:16]);
      end

      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule